// File: doc/BRIEF.md
# Six-Mode Interval Counter Channel

This block is a single down-counting channel of an interval timer. A one-cycle write strobe loads a mode number (0 to 5) and a 16-bit start value N at the same time. From then on the block drives one output level. It uses the gate input as a counting enable, as a start trigger, or as both, depending on the mode. There are six modes:

- a level that stays low until the count expires,
- a gate-triggered one-shot that can be restarted,
- a divide-by-N pulse train,
- a square wave,
- a single strobe started by software,
- a single strobe started by the gate.

Everything runs on one clock. The gate input may change at any time. Two flops synchronise it before any edge is detected. The counter is one bit wider than the write port, so a written value of 0 gives a span of 65536 cycles.

Top module: `tmr_channel`

## Requirements
- R1: After reset, OUT is high and stays high when GATE toggles before any write.
- R2: A GATE change acts at the third rising CLK edge after it. A rising edge is a synchronised sample that is high where the previous sample was low.
- R3: Mode 0 (wr_mode=0): OUT goes low at the write edge. With GATE high it stays low for exactly N cycles, then stays high until the next write.
- R4: In mode 0, every cycle of synchronised GATE low during the count freezes the counter, so the low time grows by one cycle.
- R5: Mode 1 (wr_mode=1): after the write OUT is high. Each GATE rising edge drives OUT low for N cycles. A rising edge during the low time restarts the N count.
- R6: Mode 2 (wr_mode=2) with GATE high: from the write edge OUT repeats N-1 cycles high and then one cycle low, reloading itself without end.
- R7: In modes 2 and 3, synchronised GATE low forces OUT high and halts counting. The next rising edge reloads N, so in mode 2 the low cycle follows N-1 cycles after that edge acts.
- R8: Mode 3 (wr_mode=3) with GATE high: OUT is high for ceil(N/2) cycles and low for floor(N/2) cycles, repeated, starting high at the write edge.
- R9: Mode 4 (wr_mode=4): OUT is high from the write edge for N gate-high cycles, then low for one cycle, then high with no reload.
- R10: Mode 5 (wr_mode=5): the count starts when a GATE rising edge acts, regardless of the GATE level afterwards. N cycles later OUT is low for one cycle. A new rising edge reloads N.
- R11: A written count of 0 acts as 65536.
- R12: A write during a count abandons it and restarts the channel with the new mode and count from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle strobe that loads wr_mode and wr_count |
| wr_mode | input | 3 | Mode select; 6 and 7 act as 2 and 3 |
| wr_count | input | 16 | Start value N, 0 meaning 65536 |
| gate_in | input | 1 | Asynchronous gate, used as enable and/or trigger |
| out | output | 1 | Channel waveform |

## Verification
The hardest situations to reach are the gate-driven ones: a retrigger that lands inside a one-shot, a strobe restarted mid-count, and a pause in the middle of a count. Each depends on exactly where a gate edge falls relative to the synchronizer. The bench drives the gate at falling clock edges and uses the fixed three-edge latency to place retriggers an exact number of cycles apart. It then measures every high and low run of OUT in cycles. To make the first run of each pattern begin at a measurable edge, the bench first parks OUT low with a long mode-0 count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    MD_TC_INT    = 3'd0,
    MD_ONESHOT   = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } tmr_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RUN    = 2'd1,
    PH_STROBE = 2'd2
  } tmr_phase_e;

  // codes 6 and 7 fold onto the two periodic modes
  function automatic tmr_mode_e decode_mode(input logic [2:0] code);
    if (code[2] && code[1]) return tmr_mode_e'({1'b0, code[1:0]});
    return tmr_mode_e'(code);
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/tmr_gate_sync.sv
module tmr_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_async,
  output logic gate_lvl,
  output logic gate_rise
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], gate_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign gate_lvl  = sync_q[STAGES-1];
  assign gate_rise = gate_lvl & ~prev_q;

  // R2
  gate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !gate_rise);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tmr_mode_e        wr_mode,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             gate_lvl,
  input  logic             gate_rise,
  output logic             out_level
);

  localparam int             CW   = CNT_W + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << CNT_W;
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);

  tmr_mode_e   mode_q, mode_d;
  tmr_phase_e  phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d, reload_q, reload_d, load_n;
  logic        out_q, out_d, state_en;

  function automatic logic [CW-1:0] half_up(input logic [CW-1:0] v);
    return (v + ONE) >> 1;
  endfunction

  assign load_n   = (wr_count == '0) ? FULL : {1'b0, wr_count};
  assign state_en = wr_en | gate_rise | (phase_q != PH_IDLE);

  always_comb begin
    mode_d   = mode_q;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    reload_d = reload_q;
    out_d    = out_q;
    if (wr_en) begin
      mode_d   = wr_mode;
      reload_d = load_n;
      cnt_d    = load_n;
      out_d    = 1'b1;
      phase_d  = PH_RUN;
      unique case (wr_mode)
        MD_TC_INT:                 out_d = 1'b0;
        MD_ONESHOT, MD_HW_STROBE:  phase_d = PH_IDLE;
        MD_SQUARE:                 cnt_d = half_up(load_n);
        default: ;
      endcase
    end else begin
      unique case (mode_q)
        MD_TC_INT: begin
          if (phase_q == PH_RUN && gate_lvl) begin
            if (cnt_q == ONE) begin
              out_d   = 1'b1;
              phase_d = PH_IDLE;
            end else cnt_d = cnt_q - ONE;
          end
        end
        MD_ONESHOT: begin
          if (gate_rise) begin
            cnt_d   = reload_q;
            out_d   = 1'b0;
            phase_d = PH_RUN;
          end else if (phase_q == PH_RUN) begin
            if (cnt_q == ONE) begin
              out_d   = 1'b1;
              phase_d = PH_IDLE;
            end else cnt_d = cnt_q - ONE;
          end
        end
        MD_RATE: begin
          if (!gate_lvl) out_d = 1'b1;
          else if (gate_rise) begin
            cnt_d = reload_q;
            out_d = 1'b1;
          end else if (cnt_q == ONE) begin
            cnt_d = reload_q;
            out_d = 1'b1;
          end else begin
            if (cnt_q == TWO) out_d = 1'b0;
            cnt_d = cnt_q - ONE;
          end
        end
        MD_SQUARE: begin
          if (!gate_lvl) out_d = 1'b1;
          else if (gate_rise) begin
            cnt_d = half_up(reload_q);
            out_d = 1'b1;
          end else if (cnt_q == ONE) begin
            out_d = ~out_q;
            cnt_d = out_q ? (reload_q >> 1) : half_up(reload_q);
          end else cnt_d = cnt_q - ONE;
        end
        default: begin
          if (mode_q == MD_HW_STROBE && gate_rise) begin
            cnt_d   = reload_q;
            out_d   = 1'b1;
            phase_d = PH_RUN;
          end else if (phase_q == PH_STROBE) begin
            out_d   = 1'b1;
            phase_d = PH_IDLE;
          end else if (phase_q == PH_RUN && (gate_lvl || mode_q == MD_HW_STROBE)) begin
            if (cnt_q == ONE) begin
              out_d   = 1'b0;
              phase_d = PH_STROBE;
            end else cnt_d = cnt_q - ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_TC_INT;
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      reload_q <= '0;
      out_q    <= 1'b1;
    end else if (state_en) begin
      mode_q   <= mode_d;
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      out_q    <= out_d;
    end
  end

  assign out_level = out_q;

  // R3
  tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TC_INT && out_q && !wr_en) |=> out_q);

  // R12
  load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == MD_TC_INT) |=> !out_q);

  // R5
  trig_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT && gate_rise && !wr_en) |=> !out_q);

  // R6
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && !out_q && !wr_en) |=> out_q);

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {MD_RATE, MD_SQUARE} && !gate_lvl && !wr_en) |=> out_q);

  // R9
  strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {MD_SW_STROBE, MD_HW_STROBE} && !out_q && !wr_en) |=> out_q);

  // R10
  hw_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_HW_STROBE && phase_q == PH_IDLE && !gate_rise && !wr_en)
      |=> (out_q && $stable(cnt_q)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_mode,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             gate_in,
  output logic             out
);

  logic rst_n_sync;
  logic gate_lvl;
  logic gate_rise;

  tmr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  tmr_gate_sync #(.STAGES(SYNC_STAGES)) i_gate_sync (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .gate_async (gate_in),
    .gate_lvl   (gate_lvl),
    .gate_rise  (gate_rise)
  );

  tmr_core #(.CNT_W(CNT_W)) i_core (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (wr_en),
    .wr_mode   (decode_mode(wr_mode)),
    .wr_count  (wr_count),
    .gate_lvl  (gate_lvl),
    .gate_rise (gate_rise),
    .out_level (out)
  );

endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_mode;
  logic [15:0] wr_count;
  logic        gate_in;
  logic        out;

  always #2 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_mode  (wr_mode),
    .wr_count (wr_count),
    .gate_in  (gate_in),
    .out      (out)
  );

  typedef struct {
    logic  lvl;
    int    len;
    string tag;
  } run_t;

  run_t exp_q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   track = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: out=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic expect_run(input logic lvl, input int len, input string tag);
    run_t r;
    r.lvl = lvl; r.len = len; r.tag = tag;
    exp_q.push_back(r);
  endtask

  // caller stands at a falling edge; the write takes effect at the next rising edge
  task automatic wr(input int m, input int n);
    wr_en = 1'b1; wr_mode = m[2:0]; wr_count = n[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic quiet();
    track = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic arm_low();
    quiet();
    wr(0, 1000);
    @(negedge clk);
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++;
      miscompares++;
      $display("FAIL %s: %0d runs still pending, expected 0", exp_q[0].tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  // monitor: measures OUT runs in cycles and compares against the queue
  initial begin
    logic last;
    int   run_len;
    bit   valid;
    run_t e;
    last = 1'b1; run_len = 0; valid = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        last = out; run_len = 0; valid = 1'b0;
      end else if (out !== last) begin
        if (valid && exp_q.size() > 0) begin
          e = exp_q.pop_front();
          vectors++;
          if (e.lvl !== last || e.len != run_len) begin
            miscompares++;
            $display("FAIL %s: run level %0b length %0d, expected level %0b length %0d",
                     e.tag, last, run_len, e.lvl, e.len);
          end
        end
        last = out; run_len = 1; valid = track;
      end else begin
        run_len++;
        if (!track) valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_mode = '0; wr_count = '0; gate_in = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, gate activity alone does nothing
    check("R1 after reset", out, 1'b1);
    gate_in = 1'b0; repeat (4) @(negedge clk);
    check("R1 gate low", out, 1'b1);
    gate_in = 1'b1; repeat (4) @(negedge clk);
    check("R1 gate high", out, 1'b1);

    // R3 mode 0 basic
    quiet(); expect_run(1'b0, 5, "R3"); track = 1'b1;
    wr(0, 5); drain(100);
    repeat (20) @(negedge clk);
    check("R3 holds high", out, 1'b1);

    // R4 pause for four cycles inside a count of 10
    quiet(); expect_run(1'b0, 14, "R4"); track = 1'b1;
    wr(0, 10); repeat (2) @(negedge clk);
    gate_in = 1'b0; repeat (4) @(negedge clk);
    gate_in = 1'b1; drain(100);

    // R12 rewrite five cycles into a count
    quiet(); expect_run(1'b0, 8, "R12"); track = 1'b1;
    wr(0, 20); repeat (4) @(negedge clk);
    wr(0, 3); drain(100);

    // R5 one-shot and retrigger
    quiet(); gate_in = 1'b0; repeat (4) @(negedge clk);
    expect_run(1'b0, 6, "R5"); track = 1'b1;
    wr(1, 6); repeat (3) @(negedge clk);
    gate_in = 1'b1; drain(100);
    quiet(); gate_in = 1'b0; repeat (4) @(negedge clk);
    expect_run(1'b0, 9, "R5 retrigger"); track = 1'b1;
    gate_in = 1'b1; repeat (2) @(negedge clk);
    gate_in = 1'b0; @(negedge clk);
    gate_in = 1'b1; drain(100);

    // R6 divide by four
    arm_low();
    expect_run(1'b1, 3, "R6"); expect_run(1'b0, 1, "R6");
    expect_run(1'b1, 3, "R6"); expect_run(1'b0, 1, "R6");
    track = 1'b1; wr(2, 4); drain(100);

    // R7 gate low forces high, rise reloads
    quiet(); gate_in = 1'b0; repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      check("R7 forced high", out, 1'b1);
      @(negedge clk);
    end
    gate_in = 1'b1; repeat (5) @(negedge clk);
    check("R7 high before pulse", out, 1'b1);
    @(negedge clk); check("R7 pulse after reload", out, 1'b0);
    @(negedge clk); check("R7 high after pulse", out, 1'b1);

    // R8 square wave, even and odd
    arm_low();
    expect_run(1'b1, 3, "R8 even"); expect_run(1'b0, 3, "R8 even");
    expect_run(1'b1, 3, "R8 even"); expect_run(1'b0, 3, "R8 even");
    track = 1'b1; wr(3, 6); drain(100);
    arm_low();
    expect_run(1'b1, 4, "R8 odd"); expect_run(1'b0, 3, "R8 odd");
    expect_run(1'b1, 4, "R8 odd"); expect_run(1'b0, 3, "R8 odd");
    track = 1'b1; wr(3, 7); drain(100);

    // R9 software strobe, then with a three-cycle pause
    arm_low();
    expect_run(1'b1, 5, "R9"); expect_run(1'b0, 1, "R9");
    track = 1'b1; wr(4, 5); drain(100);
    repeat (20) @(negedge clk);
    check("R9 no reload", out, 1'b1);
    arm_low();
    expect_run(1'b1, 8, "R9 paused"); expect_run(1'b0, 1, "R9 paused");
    track = 1'b1; wr(4, 5);
    gate_in = 1'b0; repeat (3) @(negedge clk);
    gate_in = 1'b1; drain(100);

    // R10 hardware strobe: three edges of gate latency (R2) plus N
    gate_in = 1'b0; arm_low(); repeat (3) @(negedge clk);
    expect_run(1'b1, 7, "R2 and R10"); expect_run(1'b0, 1, "R10");
    track = 1'b1; wr(5, 4);
    gate_in = 1'b1; drain(100);
    gate_in = 1'b0; arm_low(); repeat (3) @(negedge clk);
    expect_run(1'b1, 9, "R10 retrigger"); expect_run(1'b0, 1, "R10 retrigger");
    track = 1'b1; wr(5, 4);
    gate_in = 1'b1; @(negedge clk);
    gate_in = 1'b0; @(negedge clk);
    gate_in = 1'b1; drain(100);

    // R11 zero count
    quiet(); expect_run(1'b0, 65536, "R11"); track = 1'b1;
    wr(0, 0); drain(70000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule